// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches eight external interrupt pins of a small microcontroller. Each pin is synchronised into the core clock domain and compared against its value from the previous cycle. A per-line sense mode decides what counts as a trigger: a low level, any change, a falling edge or a rising edge. An edge-sensed trigger sets that line's pending flag. A level-sensed line keeps no flag. Its request follows the synchronised pin level directly.

Software reaches three kinds of state through a small register port: an enable mask, the pending flags (write one to clear), and two sense-mode registers. A line requests the CPU when its enable bit and the global interrupt enable are both set, and it is either flagged (edge modes) or low (level mode). The block reports the lowest-numbered active request as an index. A vector acknowledge clears that line's flag.

The pins are sampled regardless of their direction, so software that drives a pin as an output can raise an interrupt with it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable mask, the flags and both sense registers read zero, and no request is asserted.
- R2: The register map is as follows. Address 0 is the enable mask, bit k for line k. Address 1 is the flag register. Address 2 holds the sense fields of lines 0..3 and address 3 holds those of lines 4..7. Line k uses bits [2(k%4)+1 : 2(k%4)] of register 2+k/4. The mask and sense registers read back what was written. Reads are combinational from `reg_addr_i`.
- R3: Sense code 2'b11 is rising edge. A 0-to-1 pin change sets the flag; the flag reads one on the third rising clock edge after the pin changes and not before. A 1-to-0 change does not set it.
- R4: Sense code 2'b10 is falling edge. Only a 1-to-0 pin change sets the flag.
- R5: Sense code 2'b01 is any change. Either pin transition sets the flag.
- R6: Sense code 2'b00 is low level. The line's flag always reads zero. `irq_o[k]` is high while the synchronised pin is low, the enable bit is set and `gie_i` is high; it follows the pin with two clock edges of delay.
- R7: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged. A write never sets a flag.
- R8: If a trigger and a software clear reach the same flag in the same cycle, the flag ends up set.
- R9: For edge-sensed lines, `irq_o[k]` equals `gie_i & mask[k] & flag[k]`. With `gie_i` low, no request is asserted.
- R10: `irq_any_o` is the OR of `irq_o`. `irq_id_o` is the index of the lowest-numbered asserted bit of `irq_o`.
- R11: A clock edge with `ack_i` high and `irq_any_o` high clears the flag of line `irq_id_o`. Other flags are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | External interrupt pins (asynchronous) |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ack_i | input | 1 | Vector acknowledge for line `irq_id_o` |
| irq_o | output | 8 | Per-line interrupt request |
| irq_any_o | output | 1 | Any request asserted |
| irq_id_o | output | 3 | Lowest-numbered active request |

## Verification
The bench aims a flag clear at the exact cycle in which an edge arrives. A design that lets the clear win would lose that interrupt. It checks the flag one edge before and on the edge where it should appear, which catches a synchroniser that is one stage short or long. It checks that a level line shows no flag and that its request drops when the pin rises. A design that latched level triggers would keep requesting. Random pin, mask, enable and acknowledge traffic with mixed sense modes checks the lowest-index pick and that an acknowledge clears only the serviced line.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned ADDR_MASK = 0;
  localparam int unsigned ADDR_FLAG = 1;
  localparam int unsigned ADDR_SNS0 = 2;
endpackage

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   pins_i,
  input  logic [2*N-1:0] sense_i,
  output logic [N-1:0]   trig_o,
  output logic [N-1:0]   level_o,
  output logic [N-1:0]   low_o
);
  import ext_irq_pkg::*;

  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    sense_e mode;
    assign mode = sense_e'(sense_i[2*i +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_ANY:  trig_o[i] = s2_q[i] ^ prev_q[i];
        SENSE_FALL: trig_o[i] = prev_q[i] & ~s2_q[i];
        SENSE_RISE: trig_o[i] = ~prev_q[i] & s2_q[i];
        default:    trig_o[i] = 1'b0;
      endcase
    end
    assign level_o[i] = (mode == SENSE_LOW);
  end

  assign low_o = ~s2_q;

  // level lines never produce an edge trigger
  a_r6_level_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o & level_o) == '0);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
  parameter int N      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      mask_o,
  output logic [2*N-1:0]    sense_o
);
  import ext_irq_pkg::*;
  localparam int LPR = N / 2;
  localparam int NSR = N / LPR;

  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  mask_q <= '0;
    else if (we_i && addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i;
  end

  for (genvar j = 0; j < NSR; j++) begin : g_sns
    logic [N-1:0] sns_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      sns_q <= '0;
      else if (we_i && addr_i == ADDR_W'(ADDR_SNS0 + j)) sns_q <= wdata_i;
    end
    assign sense_o[j*N +: N] = sns_q;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] wr_clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  // set dominates clear; level lines hold nothing
  assign flag_d = ((flag_q & ~wr_clr_i & ~ack_clr_i) | trig_i) & ~level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r6_level_flag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != '0) |=> ((flag_o & $past(level_i)) == '0));
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_i & ~level_i) != '0) |=>
      ((flag_o & $past(trig_i & ~level_i)) == $past(trig_i & ~level_i)));
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i != '0) |=> ((flag_o & $past(wr_clr_i & ~trig_i)) == '0));
  a_r7_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == '0) |=> ((flag_o & ~$past(flag_o)) == '0));
endmodule

// File: rtl/ext_irq_pick.sv
module ext_irq_pick #(
  parameter int N    = 8,
  parameter int ID_W = 3
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) id_o = ID_W'(i);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter  int N      = 8,
  localparam int NSR    = 2,
  localparam int ADDR_W = $clog2(NSR + 2),
  localparam int ID_W   = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pins_i,
  input  logic              gie_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  input  logic              ack_i,
  output logic [N-1:0]      irq_o,
  output logic              irq_any_o,
  output logic [ID_W-1:0]   irq_id_o
);
  import ext_irq_pkg::*;

  logic [N-1:0]   mask, flag, trig, level, low, wr_clr, ack_clr;
  logic [2*N-1:0] sense;

  ext_irq_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mask_o(mask), .sense_o(sense)
  );

  ext_irq_detect #(.N(N)) u_det (
    .clk_i, .rst_ni, .pins_i, .sense_i(sense),
    .trig_o(trig), .level_o(level), .low_o(low)
  );

  assign wr_clr = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_FLAG)) ? reg_wdata_i : '0;

  always_comb begin
    ack_clr = '0;
    if (ack_i && irq_any_o) ack_clr[irq_id_o] = 1'b1;
  end

  ext_irq_flags #(.N(N)) u_flags (
    .clk_i, .rst_ni, .trig_i(trig), .level_i(level),
    .wr_clr_i(wr_clr), .ack_clr_i(ack_clr), .flag_o(flag)
  );

  assign irq_o = {N{gie_i}} & mask & ((level & low) | (~level & flag));

  ext_irq_pick #(.N(N), .ID_W(ID_W)) u_pick (
    .req_i(irq_o), .any_o(irq_any_o), .id_o(irq_id_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(ADDR_MASK):    reg_rdata_o = mask;
      ADDR_W'(ADDR_FLAG):    reg_rdata_o = flag;
      ADDR_W'(ADDR_SNS0):    reg_rdata_o = sense[0 +: N];
      default:               reg_rdata_o = sense[N +: N];
    endcase
  end

  a_r9_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (irq_o == '0));
  a_r10_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> (irq_o[irq_id_o] && ((irq_o & ((N'(1) << irq_id_o) - N'(1))) == '0)));
  a_r11_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_any_o && !trig[irq_id_o]) |=> !flag[$past(irq_id_o)]);
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int CLK_T = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] pins = 8'hFF;
  logic       gie = 0, we = 0, ack = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, irq;
  logic       any;
  logic [2:0] id;

  int total = 0, bad = 0;
  logic [1:0] mode [8];
  logic [7:0] flag_m = 0, mask_m = 0;

  always #(CLK_T/2) clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .gie_i(gie),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .irq_o(irq), .irq_any_o(any), .irq_id_o(id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [7:0] sns_byte(input int r);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) b[2*k +: 2] = mode[r*4 + k];
    return b;
  endfunction

  task automatic set_modes();
    wr(2'd2, sns_byte(0));
    wr(2'd3, sns_byte(1));
    for (int k = 0; k < 8; k++) if (mode[k] == 2'b00) flag_m[k] = 1'b0;
  endtask

  function automatic logic [7:0] exp_irq();
    logic [7:0] e;
    for (int k = 0; k < 8; k++)
      e[k] = gie & mask_m[k] & ((mode[k] == 2'b00) ? ~pins[k] : flag_m[k]);
    return e;
  endfunction

  function automatic int low_idx(input logic [7:0] v);
    for (int k = 0; k < 8; k++) if (v[k]) return k;
    return 0;
  endfunction

  function automatic logic trig_of(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'b01:   return o ^ n;
      2'b10:   return o & ~n;
      2'b11:   return ~o & n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply_pins(input logic [7:0] np);
    logic [7:0] op;
    op = pins;
    @(negedge clk); pins = np;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++)
      if (trig_of(mode[k], op[k], np[k])) flag_m[k] = 1'b1;
  endtask

  task automatic chk_out(input string tag);
    logic [7:0] e;
    #1 e = exp_irq();
    chk(irq == e, {tag, " irq"}, irq, e);
    chk(any == (e != 0), {tag, " R10 any"}, any, e != 0);
    if (e != 0) chk(id == 3'(low_idx(e)), {tag, " R10 id"}, id, low_idx(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 8; k++) mode[k] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk(d == 0, "R1 reg reset", d, 0);
    end
    chk(irq == 0 && !any, "R1 irq reset", irq, 0);

    // R2 readback
    wr(2'd0, 8'hA5); rd(2'd0, d); chk(d == 8'hA5, "R2 mask rb", d, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, d); chk(d == 8'h3C, "R2 sns0 rb", d, 8'h3C);
    wr(2'd3, 8'hC3); rd(2'd3, d); chk(d == 8'hC3, "R2 sns1 rb", d, 8'hC3);
    wr(2'd0, 8'h00);

    // line0 rise, line1 fall, line2 any, line3 low, rest rise
    mode[0] = 2'b11; mode[1] = 2'b10; mode[2] = 2'b01; mode[3] = 2'b00;
    for (int k = 4; k < 8; k++) mode[k] = 2'b11;
    set_modes();

    // R3 rising: falling change ignored
    apply_pins(8'hFE);
    rd(2'd1, d); chk(d[0] == 0, "R3 fall ignored", d, 0);
    // R3 latency: flag visible on third edge
    @(negedge clk); pins = 8'hFF;
    repeat (2) @(negedge clk); #1 chk(rdata[0] == 0 || addr != 1, "R3 early", rdata, 0);
    @(negedge clk); #1 chk(rdata[0] == 1, "R3 set on third edge", rdata, 1);
    flag_m[0] = 1;

    // R7 write zero no effect, write one clears
    wr(2'd1, 8'h00); rd(2'd1, d); chk(d[0] == 1, "R7 write zero", d, 1);
    wr(2'd1, 8'h01); rd(2'd1, d); chk(d[0] == 0, "R7 write one", d, 0);
    flag_m[0] = 0;

    // R4 falling
    apply_pins(8'hFD); rd(2'd1, d); chk(d == 8'h02, "R4 falling set", d, 8'h02);
    wr(2'd1, 8'h02); flag_m[1] = 0;
    apply_pins(8'hFF); rd(2'd1, d); chk(d == 8'h00, "R4 rise ignored", d, 0);

    // R5 any change both ways
    apply_pins(8'hFB); rd(2'd1, d); chk(d == 8'h04, "R5 any fall", d, 8'h04);
    wr(2'd1, 8'h04); flag_m[2] = 0;
    apply_pins(8'hFF); rd(2'd1, d); chk(d == 8'h04, "R5 any rise", d, 8'h04);
    wr(2'd1, 8'h04); flag_m[2] = 0;

    // R6 level: no flag, request follows pin
    gie = 1; wr(2'd0, 8'h08); mask_m = 8'h08;
    @(negedge clk); pins = 8'hF7;
    @(negedge clk); #1 chk(irq[3] == 0, "R6 before sync", irq, 0);
    @(negedge clk); #1 chk(irq[3] == 1, "R6 level request", irq, 8'h08);
    rd(2'd1, d); chk(d == 0, "R6 flag reads zero", d, 0);
    apply_pins(8'hFF); chk_out("R6 level release");

    // R8 set beats clear in the same cycle
    wr(2'd0, 8'h00); mask_m = 0;
    apply_pins(8'hFE);
    @(negedge clk); pins = 8'hFF;
    @(negedge clk);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk(d[0] == 1, "R8 set wins", d, 1);
    flag_m[0] = 1;

    // R9 gating, R10 pick, R11 ack
    apply_pins(8'h2F); apply_pins(8'hFF); // lines 4,6,7 rise
    wr(2'd0, 8'hF1); mask_m = 8'hF1;
    gie = 0; chk_out("R9 gie off");
    gie = 1; chk_out("R9 gie on");
    chk(id == 0, "R10 lowest id", id, 0);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0; flag_m[0] = 0;
    rd(2'd1, d); chk(d == 8'hD0, "R11 ack clears only id", d, 8'hD0);
    chk_out("R11 after ack");

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int op;
      apply_pins(8'($urandom));
      rd(2'd1, d); chk(d == flag_m, "R3 R4 R5 R6 rnd flags", d, flag_m);
      chk_out("R9 rnd");
      op = $urandom % 5;
      case (op)
        0: begin logic [7:0] c; c = 8'($urandom); wr(2'd1, c); flag_m &= ~c; end
        1: begin mask_m = 8'($urandom); wr(2'd0, mask_m); end
        2: begin @(negedge clk); gie = ~gie; end
        3: begin
          logic [7:0] e; #1 e = exp_irq();
          @(negedge clk); ack = 1; @(negedge clk); ack = 0;
          if (e != 0) flag_m[low_idx(e)] = 1'b0;
        end
        default: begin
          for (int k = 0; k < 8; k++) mode[k] = 2'($urandom);
          set_modes();
        end
      endcase
      @(negedge clk); chk_out("R11 rnd op");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule